// File: doc/BRIEF.md
# Asynchronous SRAM bus timing engine

This block converts one request at a time from an internal valid/acknowledge port into a complete cycle on an asynchronous static-memory bus. It drives the address lines, an active-low chip select, output enable and write enable, an active-low address-latch strobe, and a data bus that is split into an output value, an output-enable and an input value. Each access runs through a fixed sequence of phases, and a programmable cycle count sets the length of each phase. The timing values of the selected set, the request address, the write data and the multiplexing choice are all captured on the edge that accepts the request.

Two timing sets are provided, one for reads and one for writes. When the separate-write-timing control is off, the read set serves both reads and writes. When address/data multiplexing is on, the address is first driven on the data bus under the latch strobe, and an address hold phase follows. A write-permission control can refuse every write. An optional wait input can stretch the data phase, and its active level is selectable.

States: IDLE (bus released, waiting for a request), SETUP (address setup), HOLD (address hold, multiplexed mode only), DATA (strobe phase), DONE (acknowledge cycle), TURN (bus turnaround) and REJECT (refused write). Transitions: IDLE→SETUP on acceptance when the setup count is non-zero. IDLE→HOLD on acceptance with a zero setup count in multiplexed mode. IDLE→DATA on acceptance otherwise. IDLE→REJECT for a write while writes are refused. SETUP→HOLD (multiplexed) or SETUP→DATA when the setup count expires. HOLD→DATA when the hold count expires. DATA→DONE when the data count has expired and wait is not active. DONE→TURN for a non-zero turnaround count, else DONE→IDLE. TURN→IDLE when the turnaround count expires. REJECT→IDLE always.

Top module: `sram_engine`

## Requirements
- R1: A request is accepted on the first rising edge where `req_valid` is high and the engine is idle. The address setup phase then lasts exactly the setup count (0 to 15) cycles, with `mem_cs_n` low and `mem_oe_n` and `mem_we_n` high. A count of 0 omits the phase.
- R2: With `cfg_mux_en`=1, the setup phase drives the address on `mem_dq_out` with `mem_dq_oe`=1 and `mem_adv_n`=0. A hold phase of the hold count cycles follows (a count of 0 is treated as 1), in which the address stays on the data bus and `mem_adv_n`=1. With `cfg_mux_en`=0 there is no hold phase and `mem_adv_n` stays 1.
- R3: The data phase lasts the data count cycles (1 to 255; 0 is treated as 1). On a read, `mem_oe_n`=0 and `mem_dq_oe`=0. On a write, `mem_we_n`=0, `mem_dq_oe`=1 and `mem_dq_out` carries the write data. Output enable and write enable are never low together.
- R4: The cycle after the data phase, `req_ack` is 1 for exactly one cycle with `req_err`=0, and all strobes are high. For a read, `rsp_rdata` in that cycle equals `mem_dq_in` as seen on the last data-phase cycle.
- R5: After the acknowledge cycle, the bus stays idle for the turnaround count (0 to 15) plus one cycles before the next access's first phase, even when `req_valid` is already high.
- R6: Writes with `cfg_ext_en`=1 use the write timing set (`wr_*`). Reads always use the read set (`rd_*`). Writes with `cfg_ext_en`=0 use the read set.
- R7: A write while `cfg_wr_allow`=0 is answered in the cycle after acceptance with `req_ack`=1 and `req_err`=1. `mem_cs_n` and `mem_we_n` stay high throughout, and one idle cycle follows. Reads are unaffected.
- R8: With `cfg_wait_en`=1, `mem_wait` is active when it equals `cfg_wait_pol` (1 = active high, 0 = active low). On each edge where the data count has expired and wait is active, the data phase is extended by one cycle. The phase ends on the first such edge with wait inactive.
- R9: With `cfg_wait_en`=0, `mem_wait` has no effect on the data-phase length.
- R10: While `rst_n` is low, all strobes are high, `mem_dq_oe`=0, and `req_ack` and `req_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Completion refused (write not permitted) |
| rsp_rdata | output | DW | Read data, valid with `req_ack` |
| cfg_mux_en | input | 1 | Multiplex address onto the data bus |
| cfg_wr_allow | input | 1 | Writes permitted |
| cfg_ext_en | input | 1 | Writes use the separate write timing set |
| cfg_wait_en | input | 1 | Wait input honoured |
| cfg_wait_pol | input | 1 | Active level of `mem_wait` |
| rd_setup | input | 4 | Read-set address setup cycles |
| rd_hold | input | 4 | Read-set address hold cycles |
| rd_data | input | 8 | Read-set data phase cycles |
| rd_turn | input | 4 | Read-set turnaround cycles |
| wr_setup | input | 4 | Write-set address setup cycles |
| wr_hold | input | 4 | Write-set address hold cycles |
| wr_data | input | 8 | Write-set data phase cycles |
| wr_turn | input | 4 | Write-set turnaround cycles |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address latch strobe, active low |
| mem_dq_out | output | DW | Data bus output value |
| mem_dq_oe | output | 1 | Data bus driven by the engine |
| mem_dq_in | input | DW | Data bus input value |
| mem_wait | input | 1 | Wait from memory |

## Verification
Every result follows from counts known at acceptance. After the accepting edge, the first phase is visible one cycle later. The setup, hold and data phases then last their counts, and the data phase is extended by one cycle for every edge on which wait is active after the count expires. The acknowledge appears one cycle after the data phase. The next access cannot start until the turnaround count plus one idle cycles have passed, and a refused write is acknowledged in the cycle right after acceptance. The bench rebuilds this schedule from the programmed counts as a queue of expected phases and compares every bus output on the falling edge of each cycle. It moves `mem_wait` and `mem_dq_in` only on falling edges, and puts the expected read data on the bus only in the final data cycle, so that a sample taken in any other cycle is detected.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int PH_W = 4;   // width of setup, hold and turnaround counts
    localparam int DP_W = 8;   // width of data-phase count and phase timer

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_DATA,
        ST_DONE,
        ST_TURN,
        ST_REJECT
    } eng_state_e;

    typedef struct packed {
        logic [PH_W-1:0] setup;
        logic [PH_W-1:0] hold;
        logic [DP_W-1:0] data;
        logic [PH_W-1:0] turn;
    } tset_t;
endpackage

// File: rtl/sram_tsel.sv
module sram_tsel
    import sram_pkg::*;
(
    input  logic  sel_wr,
    input  logic  ext_en,
    input  tset_t rd_set,
    input  tset_t wr_set,
    output tset_t eff
);
    tset_t raw;

    // pick the active set, then lift zero hold/data counts to one cycle
    always_comb begin
        raw = (sel_wr && ext_en) ? wr_set : rd_set;
        eff = raw;
        if (raw.hold == '0) eff.hold = PH_W'(1);
        if (raw.data == '0) eff.data = DP_W'(1);
    end
endmodule

// File: rtl/sram_ptimer.sv
module sram_ptimer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // counts down to zero and rests there until reloaded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_engine.sv
module sram_engine
    import sram_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_ack,
    output logic            req_err,
    output logic [DW-1:0]   rsp_rdata,
    input  logic            cfg_mux_en,
    input  logic            cfg_wr_allow,
    input  logic            cfg_ext_en,
    input  logic            cfg_wait_en,
    input  logic            cfg_wait_pol,
    input  logic [PH_W-1:0] rd_setup,
    input  logic [PH_W-1:0] rd_hold,
    input  logic [DP_W-1:0] rd_data,
    input  logic [PH_W-1:0] rd_turn,
    input  logic [PH_W-1:0] wr_setup,
    input  logic [PH_W-1:0] wr_hold,
    input  logic [DP_W-1:0] wr_data,
    input  logic [PH_W-1:0] wr_turn,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_cs_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic            mem_adv_n,
    output logic [DW-1:0]   mem_dq_out,
    output logic            mem_dq_oe,
    input  logic [DW-1:0]   mem_dq_in,
    input  logic            mem_wait
);
    eng_state_e st_q, st_d;

    tset_t rd_set, wr_set, tsel;
    logic [PH_W-1:0] hold_q, turn_q;
    logic [DP_W-1:0] data_q;
    logic            wr_q, mux_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q, rdata_q;

    logic            ld, last, wait_act, accept;
    logic [DP_W-1:0] ld_val;

    function automatic logic [DP_W-1:0] len_m1(input logic [DP_W-1:0] n);
        return n - {{(DP_W-1){1'b0}}, 1'b1};
    endfunction

    assign rd_set = '{setup: rd_setup, hold: rd_hold, data: rd_data, turn: rd_turn};
    assign wr_set = '{setup: wr_setup, hold: wr_hold, data: wr_data, turn: wr_turn};

    sram_tsel u_tsel (
        .sel_wr (req_write),
        .ext_en (cfg_ext_en),
        .rd_set (rd_set),
        .wr_set (wr_set),
        .eff    (tsel)
    );

    sram_ptimer #(.W(DP_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .last     (last)
    );

    assign wait_act = cfg_wait_en && (mem_wait == cfg_wait_pol);
    assign accept   = (st_q == ST_IDLE) && req_valid;

    // next state and phase-timer loading
    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write && !cfg_wr_allow) begin
                        st_d = ST_REJECT;
                    end else if (tsel.setup != '0) begin
                        st_d = ST_SETUP; ld = 1'b1; ld_val = len_m1(DP_W'(tsel.setup));
                    end else if (cfg_mux_en) begin
                        st_d = ST_HOLD;  ld = 1'b1; ld_val = len_m1(DP_W'(tsel.hold));
                    end else begin
                        st_d = ST_DATA;  ld = 1'b1; ld_val = len_m1(tsel.data);
                    end
                end
            end
            ST_SETUP: begin
                if (last) begin
                    if (mux_q) begin
                        st_d = ST_HOLD; ld = 1'b1; ld_val = len_m1(DP_W'(hold_q));
                    end else begin
                        st_d = ST_DATA; ld = 1'b1; ld_val = len_m1(data_q);
                    end
                end
            end
            ST_HOLD: begin
                if (last) begin
                    st_d = ST_DATA; ld = 1'b1; ld_val = len_m1(data_q);
                end
            end
            ST_DATA: begin
                if (last && !wait_act) st_d = ST_DONE;
            end
            ST_DONE: begin
                if (turn_q != '0) begin
                    st_d = ST_TURN; ld = 1'b1; ld_val = len_m1(DP_W'(turn_q));
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_TURN:   if (last) st_d = ST_IDLE;
            ST_REJECT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // request capture and read sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            data_q  <= '0;
            turn_q  <= '0;
            wr_q    <= 1'b0;
            mux_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                hold_q  <= tsel.hold;
                data_q  <= tsel.data;
                turn_q  <= tsel.turn;
                wr_q    <= req_write;
                mux_q   <= cfg_mux_en;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (st_q == ST_DATA && st_d == ST_DONE && !wr_q) rdata_q <= mem_dq_in;
        end
    end

    // bus and response outputs
    always_comb begin
        mem_cs_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_adv_n  = 1'b1;
        mem_dq_oe  = 1'b0;
        mem_dq_out = wdata_q;
        req_ack    = 1'b0;
        req_err    = 1'b0;
        unique case (st_q)
            ST_SETUP: begin
                mem_cs_n   = 1'b0;
                mem_adv_n  = !mux_q;
                mem_dq_oe  = mux_q;
                mem_dq_out = DW'(addr_q);
            end
            ST_HOLD: begin
                mem_cs_n   = 1'b0;
                mem_dq_oe  = 1'b1;
                mem_dq_out = DW'(addr_q);
            end
            ST_DATA: begin
                mem_cs_n  = 1'b0;
                mem_oe_n  = wr_q;
                mem_we_n  = !wr_q;
                mem_dq_oe = wr_q;
            end
            ST_DONE:   req_ack = 1'b1;
            ST_REJECT: begin
                req_ack = 1'b1;
                req_err = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/sram_engine_chk.sv
module sram_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ack,
    input logic req_err,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_adv_n,
    input logic mem_dq_oe
);
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    a_r3_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    a_r2_latch_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> (!mem_cs_n && mem_dq_oe && mem_we_n && mem_oe_n));

    a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    a_r4_ack_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (mem_cs_n && mem_we_n && mem_oe_n));

    a_r5_after_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> mem_cs_n);

    a_r7_err_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ack && mem_we_n && mem_cs_n));
endmodule

bind sram_engine sram_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ack   (req_ack),
    .req_err   (req_err),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_engine.sv
module sim_sram_engine;
    localparam int  AW = 16;
    localparam int  DW = 16;
    localparam time CLK_PERIOD = 10;
    localparam int  WDOG = 20000;

    localparam int K_IDLE = 0, K_SETUP = 1, K_HOLD = 2, K_DATA = 3, K_DONE = 4, K_REJECT = 5;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, req_valid, req_write, req_ack, req_err;
    logic [AW-1:0] req_addr, mem_addr;
    logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
    logic cfg_mux_en, cfg_wr_allow, cfg_ext_en, cfg_wait_en, cfg_wait_pol;
    logic [3:0] rd_setup, rd_hold, rd_turn, wr_setup, wr_hold, wr_turn;
    logic [7:0] rd_data, wr_data;
    logic mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe, mem_wait;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int gap = 0;

    sram_engine #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_err(req_err), .rsp_rdata(rsp_rdata),
        .cfg_mux_en(cfg_mux_en), .cfg_wr_allow(cfg_wr_allow), .cfg_ext_en(cfg_ext_en),
        .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
        .rd_setup(rd_setup), .rd_hold(rd_hold), .rd_data(rd_data), .rd_turn(rd_turn),
        .wr_setup(wr_setup), .wr_hold(wr_hold), .wr_data(wr_data), .wr_turn(wr_turn),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_adv_n(mem_adv_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_fail++;
            $display("FAIL R5 watchdog: got %0d cycles expected at most %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // compare every bus output against the expected phase kind
    task automatic check_cycle(input int kind, input string scen, input logic wr, input logic mux,
                               input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [DW-1:0] rd);
        logic e_cs, e_oe, e_we, e_adv, e_dqoe, e_ack, e_err;
        logic [DW-1:0] e_dq;
        string tag;
        e_cs = 1; e_oe = 1; e_we = 1; e_adv = 1; e_dqoe = 0; e_ack = 0; e_err = 0; e_dq = '0;
        case (kind)
            K_SETUP:  begin tag = {"R1/", scen}; e_cs = 0; e_adv = !mux; e_dqoe = mux; e_dq = a; end
            K_HOLD:   begin tag = {"R2/", scen}; e_cs = 0; e_dqoe = 1; e_dq = a; end
            K_DATA:   begin tag = {"R3/", scen}; e_cs = 0; e_oe = wr; e_we = !wr; e_dqoe = wr; e_dq = wd; end
            K_DONE:   begin tag = {"R4/", scen}; e_ack = 1; end
            K_REJECT: begin tag = {"R7/", scen}; e_ack = 1; e_err = 1; end
            default:  begin tag = {"R5/", scen}; end
        endcase
        chk(tag, "mem_cs_n", 32'(mem_cs_n), 32'(e_cs));
        chk(tag, "mem_oe_n", 32'(mem_oe_n), 32'(e_oe));
        chk(tag, "mem_we_n", 32'(mem_we_n), 32'(e_we));
        chk(tag, "mem_adv_n", 32'(mem_adv_n), 32'(e_adv));
        chk(tag, "mem_dq_oe", 32'(mem_dq_oe), 32'(e_dqoe));
        chk(tag, "req_ack", 32'(req_ack), 32'(e_ack));
        chk(tag, "req_err", 32'(req_err), 32'(e_err));
        if (kind == K_SETUP || kind == K_HOLD || kind == K_DATA)
            chk(tag, "mem_addr", 32'(mem_addr), 32'(a));
        if (e_dqoe)
            chk(tag, "mem_dq_out", 32'(mem_dq_out), 32'(e_dq));
        if (kind == K_DONE && !wr)
            chk(tag, "rsp_rdata", 32'(rsp_rdata), 32'(rd));
    endtask

    // one request, checked cycle by cycle against a schedule built from the counts
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [DW-1:0] rd, input int wait_hold, input string scen);
        int s, h, d, t, w, k;
        logic blocked, mux;
        int q[$];
        mux = cfg_mux_en;
        if (wr && cfg_ext_en) begin
            s = wr_setup; h = wr_hold; d = wr_data; t = wr_turn;
        end else begin
            s = rd_setup; h = rd_hold; d = rd_data; t = rd_turn;
        end
        if (h == 0) h = 1;
        if (!mux) h = 0;
        if (d == 0) d = 1;
        w = cfg_wait_en ? wait_hold : 0;
        blocked = wr && !cfg_wr_allow;

        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        mem_dq_in = ~rd; mem_wait = !cfg_wait_pol;

        for (int g = 0; g < gap; g++) q.push_back(K_IDLE);
        if (blocked) q.push_back(K_REJECT);
        else begin
            for (int i = 0; i < s; i++) q.push_back(K_SETUP);
            for (int i = 0; i < h; i++) q.push_back(K_HOLD);
            for (int i = 0; i < d + w; i++) q.push_back(K_DATA);
            q.push_back(K_DONE);
        end

        k = 0;
        foreach (q[i]) begin
            @(negedge clk);
            check_cycle(q[i], scen, wr, mux, a, wd, rd);
            if (q[i] == K_DATA) begin
                k++;
                mem_wait  = (k >= d && k < d + wait_hold) ? cfg_wait_pol : !cfg_wait_pol;
                mem_dq_in = (k == d + w) ? rd : ~rd;
            end
            if (q[i] == K_DONE || q[i] == K_REJECT) begin
                req_valid = 0;
                mem_wait  = !cfg_wait_pol;
            end
        end
        gap = blocked ? 1 : t + 1;
    endtask

    task automatic idle(input int n, input string scen);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_cycle(K_IDLE, scen, 1'b0, 1'b0, '0, '0, '0);
            if (gap > 0) gap--;
        end
    endtask

    task automatic set_rd(input int s, input int h, input int d, input int t);
        rd_setup = 4'(s); rd_hold = 4'(h); rd_data = 8'(d); rd_turn = 4'(t);
    endtask

    task automatic set_wr(input int s, input int h, input int d, input int t);
        wr_setup = 4'(s); wr_hold = 4'(h); wr_data = 8'(d); wr_turn = 4'(t);
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        cfg_mux_en = 0; cfg_wr_allow = 1; cfg_ext_en = 0; cfg_wait_en = 0; cfg_wait_pol = 1;
        set_rd(2, 1, 3, 1); set_wr(1, 2, 2, 0);
        mem_dq_in = '0; mem_wait = 0;

        // R10: reset state
        @(negedge clk);
        @(negedge clk);
        check_cycle(K_IDLE, "R10", 1'b0, 1'b0, '0, '0, '0);
        rst_n = 1;
        gap = 0;

        // basic read and write, shared timing set
        access(1'b0, 16'h1234, 16'h0000, 16'hA5C3, 0, "R3");
        access(1'b1, 16'h0042, 16'hBEEF, 16'h0000, 0, "R6");
        idle(2, "R5");

        // separate write timing set
        cfg_ext_en = 1;
        access(1'b1, 16'h0101, 16'h7E57, 16'h0000, 0, "R6");
        access(1'b0, 16'h0202, 16'h0000, 16'h3C3C, 0, "R6");
        cfg_ext_en = 0;

        // zero setup, zero data count
        set_rd(0, 1, 0, 0);
        access(1'b0, 16'h0303, 16'h0000, 16'h5A5A, 0, "R1");
        access(1'b1, 16'h0404, 16'h1111, 16'h0000, 0, "R1");

        // long turnaround with the next request already waiting
        set_rd(1, 1, 2, 6);
        access(1'b0, 16'h0505, 16'h0000, 16'h0F0F, 0, "R5");
        access(1'b0, 16'h0606, 16'h0000, 16'hF0F0, 0, "R5");
        idle(8, "R5");

        // multiplexed address/data
        cfg_mux_en = 1;
        set_rd(2, 3, 2, 1);
        access(1'b0, 16'h1357, 16'h0000, 16'h2468, 0, "R2");
        access(1'b1, 16'h9ABC, 16'hDEF0, 16'h0000, 0, "R2");
        set_rd(0, 0, 1, 0);
        access(1'b0, 16'h4444, 16'h0000, 16'h8888, 0, "R2");
        cfg_mux_en = 0;
        idle(2, "R5");

        // write inhibit
        set_rd(1, 1, 2, 0);
        cfg_wr_allow = 0;
        access(1'b1, 16'h0707, 16'hCAFE, 16'h0000, 0, "R7");
        access(1'b0, 16'h0808, 16'h0000, 16'h7777, 0, "R7");
        access(1'b1, 16'h0909, 16'hFACE, 16'h0000, 0, "R7");
        cfg_wr_allow = 1;
        idle(2, "R7");

        // wait handling, both polarities
        cfg_wait_en = 1; cfg_wait_pol = 1;
        set_rd(1, 1, 3, 0);
        access(1'b0, 16'h0A0A, 16'h0000, 16'h1357, 3, "R8");
        idle(2, "R8");
        cfg_wait_pol = 0;
        idle(1, "R8");
        access(1'b1, 16'h0B0B, 16'h2222, 16'h0000, 2, "R8");
        set_rd(0, 1, 1, 0);
        access(1'b0, 16'h0C0C, 16'h0000, 16'hABCD, 4, "R8");
        idle(2, "R8");

        // wait pin active but disabled
        cfg_wait_en = 0; cfg_wait_pol = 1;
        idle(1, "R9");
        set_rd(1, 1, 2, 0);
        access(1'b0, 16'h0D0D, 16'h0000, 16'h6543, 4, "R9");
        idle(2, "R9");

        // longest data phase
        set_rd(15, 1, 255, 15);
        access(1'b0, 16'hFFFF, 16'h0000, 16'h0FF0, 0, "R3");
        idle(18, "R5");

        summary();
        $finish;
    end
endmodule